// File: doc/BRIEF.md
# ADC Result Packer with Per-Channel Averaging

This block takes a stream of tagged ADC conversion results and writes them as bytes into a memory through a plain write port (address, byte, write enable). A start pulse captures a channel-enable mask, a per-channel sample count `n = 2^n_log2` and a base address. The block then works through the enabled channels from the lowest index to the highest. For each one it collects `n` results whose tag matches that channel. It writes each result as two bytes, then appends a four-byte trailer: the channel index, the division remainder, and the 16-bit average.

Each channel record is `2n+4` bytes long. Records for consecutive enabled channels sit back to back from the base address, with no gap for disabled channels. The sample handshake is a valid/ready pair. Ready is high only while the block is waiting for the next result of the current channel. At most one memory write is issued per clock. When the last trailer byte has been written, the block raises a single-cycle completion pulse and returns to idle.

Top module: `adc_rec_packer`

## Requirements
- R1: Each accepted result occupies two consecutive bytes. The byte at the lower address holds result bits 11:8 in its low nibble, with its upper nibble zero. The next byte holds bits 7:0. Result k (k from 0) of a record sits at record offsets 2k and 2k+1.
- R2: Record offset 2n holds the channel index, zero-extended to 8 bits.
- R3: `n_log2` (0 to 8) is sampled at start and sets n = 2^n_log2. Offsets 2n+2 and 2n+3 hold (sum of the n results) >> n_log2, high byte first.
- R4: Offset 2n+1 holds the sum modulo n, truncated to 8 bits. It is 0 when n = 1.
- R5: Records follow the ascending index order of the enabled channels. The record of the m-th enabled channel starts at base + (m-1)(2n+4), and disabled channels leave no gap. Every write goes to the address one above the previous write of the run.
- R6: A run issues exactly (number of enabled channels)·(2n+4) writes, at most one per cycle, and nothing else.
- R7: `smp_ready` is high only while the block waits for a result and is never high during a write cycle. A valid result whose channel tag differs from the current channel is ignored and writes nothing.
- R8: The sum of 256 full-scale results (0xFFF) does not wrap: the average is 0x0FFF and the remainder is 0.
- R9: `done` is high for exactly one cycle, one cycle after the last trailer byte is written. `busy` is high from the cycle after start up to and including the `done` cycle, and low afterwards.
- R10: A start pulse that arrives while `busy` is high has no effect. Mask, count and base are taken only at the accepted start.
- R11: A start with an all-zero mask gives `done` in the next cycle and no writes.
- R12: While reset is asserted and right after it, `busy`, `done`, `mem_we` and `smp_ready` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a run (taken only when idle) |
| ch_en | input | NCH | Channel-enable mask, bit i enables channel i |
| n_log2 | input | 4 | log2 of results per channel, 0 to MAXN_LOG |
| base_addr | input | ADDR_W | Byte address of the first record |
| smp_valid | input | 1 | A result is offered |
| smp_ready | output | 1 | Block is waiting for a result |
| smp_data | input | RES_W | Conversion result, right-aligned |
| smp_chan | input | CH_W | Channel tag of the offered result |
| mem_we | output | 1 | Byte write strobe |
| mem_addr | output | ADDR_W | Byte write address |
| mem_wdata | output | 8 | Byte write data |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The checks assume that `n_log2` never exceeds 8 at an accepted start, that a run's records fit below the top of the address space, and that the inputs are stable around the rising edge. The bench draws its counts from 0 to 8 and places its base addresses far enough down that the records of each run never wrap. It changes every input only on the falling edge. Before the first correct-tag result of each channel, it offers a result with the wrong tag while ready is high. During every run it also pulses start with a different configuration, so that both ignore rules are exercised in the run's memory image.

// File: rtl/adcpk_pkg.sv
package adcpk_pkg;

   typedef enum logic [3:0] {
      ST_IDLE,
      ST_WAIT,
      ST_HI,
      ST_LO,
      ST_CHN,
      ST_REM,
      ST_AVH,
      ST_AVL,
      ST_DONE
   } adcpk_state_e;

   function automatic logic is_write(input adcpk_state_e s);
      return (s == ST_HI) || (s == ST_LO) || (s == ST_CHN) ||
             (s == ST_REM) || (s == ST_AVH) || (s == ST_AVL);
   endfunction

endpackage

// File: rtl/adcpk_pick.sv
// Finds the lowest enabled channel whose index is not below "from".
module adcpk_pick #(
   parameter int NCH = 8,
   localparam int CH_W = $clog2(NCH)
) (
   input  logic [NCH-1:0]  mask,
   input  logic [CH_W:0]   from,
   output logic            found,
   output logic [CH_W-1:0] idx
);

   logic [NCH-1:0] elig;

   generate
      for (genvar g = 0; g < NCH; g++) begin : g_elig
         assign elig[g] = mask[g] && ((CH_W+1)'(g) >= from);
      end
   endgenerate

   always_comb begin
      found = 1'b0;
      idx   = '0;
      for (int i = NCH - 1; i >= 0; i--) begin
         if (elig[i]) begin
            found = 1'b1;
            idx   = CH_W'(i);
         end
      end
   end

endmodule

// File: rtl/adcpk_accum.sv
// Per-channel running sum, split into quotient and remainder by a power of two.
module adcpk_accum #(
   parameter int RES_W    = 12,
   parameter int MAXN_LOG = 8,
   localparam int ACC_W   = RES_W + MAXN_LOG,
   localparam int NL_W    = $clog2(MAXN_LOG + 1)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             add,
   input  logic [RES_W-1:0] din,
   input  logic [NL_W-1:0]  nlog,
   output logic [15:0]      avg,
   output logic [7:0]       rem
);

   logic [ACC_W-1:0] acc;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   acc <= '0;
      else if (clr) acc <= '0;
      else if (add) acc <= acc + ACC_W'(din);
   end

   generate
      if (MAXN_LOG == 0) begin : g_single
         assign avg = 16'(acc);
         assign rem = 8'd0;
      end else begin : g_shift
         assign avg = 16'(acc >> nlog);
         assign rem = 8'(acc & ((ACC_W'(1) << nlog) - ACC_W'(1)));
      end
   endgenerate

   // R8: the running sum never wraps while results are added
   p_acc_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (add && !clr) |=> (acc >= $past(acc)));

endmodule

// File: rtl/adc_rec_packer.sv
module adc_rec_packer
   import adcpk_pkg::*;
#(
   parameter int NCH      = 8,
   parameter int RES_W    = 12,
   parameter int MAXN_LOG = 8,
   parameter int ADDR_W   = 16,
   localparam int CH_W    = $clog2(NCH),
   localparam int NL_W    = $clog2(MAXN_LOG + 1),
   localparam int CNT_W   = MAXN_LOG + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start,
   input  logic [NCH-1:0]    ch_en,
   input  logic [NL_W-1:0]   n_log2,
   input  logic [ADDR_W-1:0] base_addr,
   input  logic              smp_valid,
   output logic              smp_ready,
   input  logic [RES_W-1:0]  smp_data,
   input  logic [CH_W-1:0]   smp_chan,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [7:0]        mem_wdata,
   output logic              busy,
   output logic              done
);

   generate
      if (NCH < 2 || NCH > 256) begin : g_bad_nch
         $error("adc_rec_packer: NCH must be 2..256");
      end
      if (RES_W < 1 || RES_W > 16) begin : g_bad_res
         $error("adc_rec_packer: RES_W must be 1..16");
      end
      if (MAXN_LOG > 8) begin : g_bad_n
         $error("adc_rec_packer: MAXN_LOG must be 0..8");
      end
   endgenerate

   adcpk_state_e      state, state_nx;
   logic [NCH-1:0]    mask_q;
   logic [NL_W-1:0]   nlog_q;
   logic [ADDR_W-1:0] ptr;
   logic [CH_W-1:0]   cur;
   logic [CNT_W-1:0]  cnt;
   logic [RES_W-1:0]  smp_q;

   logic              accept;
   logic              last_smp;
   logic [CNT_W-1:0]  n_val;
   logic [NCH-1:0]    pick_mask;
   logic [CH_W:0]     pick_from;
   logic              pick_found;
   logic [CH_W-1:0]   pick_idx;
   logic              acc_clr;
   logic [15:0]       avg;
   logic [7:0]        rem;
   logic [15:0]       word;

   assign n_val    = CNT_W'(1) << nlog_q;
   assign accept   = (state == ST_WAIT) && smp_valid && (smp_chan == cur);
   assign last_smp = (cnt + CNT_W'(1)) == n_val;

   // Idle: search the new mask from 0; end of record: search past the current channel.
   assign pick_mask = (state == ST_IDLE) ? ch_en : mask_q;
   assign pick_from = (state == ST_IDLE) ? '0 : ({1'b0, cur} + (CH_W+1)'(1));

   adcpk_pick #(.NCH(NCH)) u_pick (
      .mask  (pick_mask),
      .from  (pick_from),
      .found (pick_found),
      .idx   (pick_idx)
   );

   assign acc_clr = ((state == ST_IDLE) && start) || (state == ST_AVL);

   adcpk_accum #(.RES_W(RES_W), .MAXN_LOG(MAXN_LOG)) u_accum (
      .clk   (clk),
      .rst_n (rst_n),
      .clr   (acc_clr),
      .add   (accept),
      .din   (smp_data),
      .nlog  (nlog_q),
      .avg   (avg),
      .rem   (rem)
   );

   always_comb begin
      state_nx = state;
      unique case (state)
         ST_IDLE: if (start) state_nx = pick_found ? ST_WAIT : ST_DONE;
         ST_WAIT: if (accept) state_nx = ST_HI;
         ST_HI:   state_nx = ST_LO;
         ST_LO:   state_nx = last_smp ? ST_CHN : ST_WAIT;
         ST_CHN:  state_nx = ST_REM;
         ST_REM:  state_nx = ST_AVH;
         ST_AVH:  state_nx = ST_AVL;
         ST_AVL:  state_nx = pick_found ? ST_WAIT : ST_DONE;
         ST_DONE: state_nx = ST_IDLE;
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state  <= ST_IDLE;
         mask_q <= '0;
         nlog_q <= '0;
         ptr    <= '0;
         cur    <= '0;
         cnt    <= '0;
         smp_q  <= '0;
      end else begin
         state <= state_nx;
         if (state == ST_IDLE && start) begin
            mask_q <= ch_en;
            nlog_q <= n_log2;
            ptr    <= base_addr;
            cur    <= pick_idx;
            cnt    <= '0;
         end
         if (accept) smp_q <= smp_data;
         if (is_write(state)) ptr <= ptr + ADDR_W'(1);
         if (state == ST_LO) cnt <= cnt + CNT_W'(1);
         if (state == ST_AVL) begin
            cur <= pick_idx;
            cnt <= '0;
         end
      end
   end

   assign word = 16'(smp_q);

   always_comb begin
      unique case (state)
         ST_HI:   mem_wdata = word[15:8];
         ST_LO:   mem_wdata = word[7:0];
         ST_CHN:  mem_wdata = 8'(cur);
         ST_REM:  mem_wdata = rem;
         ST_AVH:  mem_wdata = avg[15:8];
         ST_AVL:  mem_wdata = avg[7:0];
         default: mem_wdata = 8'd0;
      endcase
   end

   assign mem_we    = is_write(state);
   assign mem_addr  = ptr;
   assign smp_ready = (state == ST_WAIT);
   assign busy      = (state != ST_IDLE);
   assign done      = (state == ST_DONE);

   // R5: back-to-back writes go to ascending consecutive addresses
   p_write_seq_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) + ADDR_W'(1)));

   // R7: the block never asks for a result during a write cycle
   p_ready_no_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
      smp_ready |-> !mem_we);

   // R9: completion lasts one cycle and the block is then idle
   p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));

   // R10: a run begins only on a start pulse
   p_start_only_r10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(start));

   // R3: the sample-count exponent stays within the supported range
   p_nlog_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !busy) |-> (n_log2 <= NL_W'(MAXN_LOG)));

endmodule

// File: tb/adc_rec_packer_test.sv
module adc_rec_packer_test;

   localparam int NCH    = 8;
   localparam int RES_W  = 12;
   localparam int ADDR_W = 16;
   localparam int NCASE  = 6;

   localparam logic [7:0]  T_MASK [NCASE] = '{8'h01, 8'h81, 8'h5A, 8'hFF, 8'h20, 8'h06};
   localparam logic [3:0]  T_NL   [NCASE] = '{4'd0, 4'd2, 4'd3, 4'd1, 4'd8, 4'd4};
   localparam logic [15:0] T_BASE [NCASE] = '{16'h0000, 16'h0100, 16'h1234, 16'h2000, 16'h4000, 16'h8000};
   localparam int          T_SEED [NCASE] = '{7, 11, 3, 5, 0, 9};

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              start = 1'b0;
   logic [NCH-1:0]    ch_en = '0;
   logic [3:0]        n_log2 = '0;
   logic [ADDR_W-1:0] base_addr = '0;
   logic              smp_valid = 1'b0;
   logic              smp_ready;
   logic [RES_W-1:0]  smp_data = '0;
   logic [2:0]        smp_chan = '0;
   logic              mem_we;
   logic [ADDR_W-1:0] mem_addr;
   logic [7:0]        mem_wdata;
   logic              busy;
   logic              done;

   int errors = 0;
   int checks = 0;
   logic [7:0] bmem [int];

   always #5 clk = ~clk;

   adc_rec_packer uut (
      .clk(clk), .rst_n(rst_n), .start(start), .ch_en(ch_en), .n_log2(n_log2),
      .base_addr(base_addr), .smp_valid(smp_valid), .smp_ready(smp_ready),
      .smp_data(smp_data), .smp_chan(smp_chan), .mem_we(mem_we),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .busy(busy), .done(done)
   );

   task automatic check(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
      end
   endtask

   function automatic int sval(input int seed, input int ch, input int k);
      if (seed == 0) return 'hFFF;
      return (seed * 37 + ch * 101 + k * 53 + k * k * 3) & 'hFFF;
   endfunction

   function automatic int rd(input int a);
      if (bmem.exists(a)) return int'(bmem[a]);
      return -1;
   endfunction

   task automatic run_case(input int ci);
      int chl[NCH];
      int nch = 0;
      int n = 1 << T_NL[ci];
      int seed = T_SEED[ci];
      int cyc = 0, wcnt = 0, lastw = -10, donecyc = -1;
      int m = 0, k = 0;
      bit inject = 1'b1, finished = 1'b0, rdy_clash = 1'b0;
      for (int i = 0; i < NCH; i++) if (T_MASK[ci][i]) begin chl[nch] = i; nch++; end
      bmem.delete();
      @(negedge clk);
      ch_en = T_MASK[ci]; n_log2 = T_NL[ci]; base_addr = T_BASE[ci]; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      cyc = 1;
      while (!finished && cyc < 20000) begin
         if (mem_we) begin
            bmem[int'(mem_addr)] = mem_wdata;
            wcnt++;
            lastw = cyc;
            if (smp_ready) rdy_clash = 1'b1;
         end
         if (done) begin
            donecyc = cyc;
            finished = 1'b1;
         end else begin
            // R10: a start with another configuration while busy
            if (cyc == 5) begin
               start = 1'b1; ch_en = 8'hFF; n_log2 = 4'd0; base_addr = 16'h0000;
            end else if (cyc == 6) begin
               start = 1'b0; ch_en = T_MASK[ci]; n_log2 = T_NL[ci]; base_addr = T_BASE[ci];
            end
            if (smp_ready && m < nch) begin
               smp_valid = 1'b1;
               if (inject) begin
                  // R7: wrong tag, must be ignored
                  smp_chan = 3'(chl[m] + 1);
                  smp_data = 12'h5A5;
                  inject = 1'b0;
               end else begin
                  smp_chan = 3'(chl[m]);
                  smp_data = 12'(sval(seed, chl[m], k));
                  k++;
                  if (k == n) begin k = 0; m++; inject = 1'b1; end
               end
            end else begin
               smp_valid = 1'b0;
            end
         end
         @(negedge clk);
         cyc++;
      end
      smp_valid = 1'b0;
      check("R9 run completes", int'(finished), 1);
      check("R6 write count", wcnt, nch * (2 * n + 4));
      check("R9 done one cycle after last write", donecyc, lastw + 1);
      check("R7 ready low during writes", int'(rdy_clash), 0);
      for (int mi = 0; mi < nch; mi++) begin
         int rb = int'(T_BASE[ci]) + mi * (2 * n + 4);
         int sum = 0;
         for (int ki = 0; ki < n; ki++) begin
            int v = sval(seed, chl[mi], ki);
            sum += v;
            check("R1 R5 high byte", rd(rb + 2 * ki), v >> 8);
            check("R1 R5 low byte", rd(rb + 2 * ki + 1), v & 'hFF);
         end
         check("R2 channel byte", rd(rb + 2 * n), chl[mi]);
         check("R4 remainder byte", rd(rb + 2 * n + 1), (sum % n) & 'hFF);
         check("R3 R8 average high", rd(rb + 2 * n + 2), ((sum / n) >> 8) & 'hFF);
         check("R3 R8 average low", rd(rb + 2 * n + 3), (sum / n) & 'hFF);
      end
      check("R9 done single cycle", int'(done), 0);
      check("R9 idle after done", int'(busy), 0);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
   end

   initial begin
      // R12: reset state
      repeat (3) @(negedge clk);
      check("R12 busy in reset", int'(busy), 0);
      check("R12 ready in reset", int'(smp_ready), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R12 busy after reset", int'(busy), 0);
      check("R12 done after reset", int'(done), 0);
      check("R12 mem_we after reset", int'(mem_we), 0);
      check("R12 ready after reset", int'(smp_ready), 0);

      for (int ci = 0; ci < NCASE; ci++) run_case(ci);

      // R11: empty mask
      begin
         int wc = 0;
         @(negedge clk);
         ch_en = '0; n_log2 = 4'd3; base_addr = 16'h0500; start = 1'b1;
         @(negedge clk);
         start = 1'b0;
         if (mem_we) wc++;
         check("R11 done next cycle", int'(done), 1);
         @(negedge clk);
         if (mem_we) wc++;
         check("R11 done is one cycle", int'(done), 0);
         check("R11 idle again", int'(busy), 0);
         check("R11 no writes", wc, 0);
      end

      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule